// File: doc/BRIEF.md
# Exception Arbitration and Entry Unit

This unit sits beside the execution pipeline of a small processor core and decides, at every instruction boundary, whether an exception is entered and which one. It gathers the candidates: an active-high reset, two asynchronous active-low interrupt pins (fast and normal), an abort line from the memory manager qualified by a cycle type, a first-word check of the data-transfer address against the 26-bit limit, and the undefined-instruction and software-interrupt decode strobes. It then picks one of them by fixed priority. For the chosen exception it emits a one-cycle take strobe together with the vector address, the new mode code and the mask-flag updates. Register banking, the datapath and coprocessor handshakes belong to the core.

The control is a three-state machine. `S_HOLD` is held while reset is high and emits nothing. The transition `S_HOLD -> S_RUN` fires on the first clock edge after reset is released and commits the reset entry. In `S_RUN`, a boundary with a winner commits that winner. The transition `S_RUN -> S_CHAIN` is taken when the winner is a transfer error (address exception or data abort) and an enabled fast interrupt is also pending. `S_CHAIN -> S_RUN` is unconditional and commits the fast-interrupt entry on the very next cycle, without waiting for a boundary.

Top module: `exc_entry_unit`

## Requirements
- R1: Each interrupt pin passes through a single synchronising register. A pin level becomes visible to selection only at the edge after the one that samples it, so a pin that first goes low just before a boundary edge is not taken at that boundary.
- R2: A synchronised low fast-interrupt level is eligible only while `flag_f` is 0, and a synchronised low normal-interrupt level only while `flag_i` is 0. A masked fast interrupt lets an unmasked normal interrupt win (vector 0x18, mode 2, set_i=1, set_f=0).
- R3: The fast interrupt beats the normal interrupt. Its entry gives vector 0x1C, mode 1, and raises both set_f and set_i.
- R4: A data transfer (`xfer_valid`=1, `cyc_type`=2'b01, `is_branch`=0) whose address has any 1 in bits 31:26 raises an address exception at the next boundary: vector 0x14, mode 3, set_i=1. Branches never raise it.
- R5: In a block transfer (`is_block`=1), only the word flagged `blk_first`=1 is checked. Later words with high address bits do not trap.
- R6: An abort in a data cycle is ignored when that cycle raises an address exception, so only one exception results. An abort during an internal cycle (`cyc_type` 2'b10 or 2'b11) is ignored.
- R7: An abort in a prefetch cycle (`cyc_type`=2'b00) marks a pending prefetch abort. The mark is taken at the next boundary it wins (vector 0x0C, mode 4) and is discarded if `flush` is asserted first.
- R8: A data abort enters vector 0x10, mode 4. If it, or an address exception, wins while an enabled fast interrupt is pending, the fast-interrupt entry follows in the very next cycle.
- R9: Undefined instruction gives vector 0x04, mode 5. Software interrupt gives vector 0x08, mode 3. Every entry raises set_i.
- R10: Priority from highest to lowest is: reset, address exception, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R11: While `rst` is high, `take_exc` stays 0. In the cycle after the first rising edge with `rst` low, the unit emits vector 0x00, mode 3, with set_f and set_i both 1.
- R12: `take_exc` is a one-cycle pulse per entry. Outside the reset and chain entries it fires only after an edge on which `boundary` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Active-high reset; also clears all internal state asynchronously |
| nfiq_pin | input | 1 | Fast interrupt request, active low, asynchronous |
| nirq_pin | input | 1 | Normal interrupt request, active low, asynchronous |
| boundary | input | 1 | High on the cycle that ends an instruction |
| abort_in | input | 1 | Memory manager abort |
| cyc_type | input | 2 | Cycle kind: 00 prefetch, 01 data, 10/11 internal |
| daddr | input | 32 | Computed data-transfer address |
| xfer_valid | input | 1 | A data-transfer address is presented this cycle |
| is_branch | input | 1 | Current instruction is a branch |
| is_block | input | 1 | Transfer is part of a block transfer |
| blk_first | input | 1 | This is the first word of the block transfer |
| flush | input | 1 | Pipeline flushed by a taken branch |
| undef_dec | input | 1 | Undefined-instruction decode strobe |
| swi_dec | input | 1 | Software-interrupt decode strobe |
| flag_f | input | 1 | Fast-interrupt mask flag |
| flag_i | input | 1 | Normal-interrupt mask flag |
| take_exc | output | 1 | Exception entry strobe |
| vec_addr | output | 32 | Vector byte address |
| mode_out | output | 3 | New mode: 1 fast, 2 normal, 3 supervisor, 4 abort, 5 undefined |
| set_f | output | 1 | Set the fast-interrupt mask |
| set_i | output | 1 | Set the normal-interrupt mask |

## Verification
Decisions register on a rising edge and appear on the outputs during the following cycle. A boundary-driven entry is therefore visible one cycle after the boundary edge. An interrupt pin needs one extra edge for its synchroniser. A transfer error or prefetch abort must first be captured on its own edge before a later boundary can take it. The chained fast-interrupt entry appears exactly one cycle after the transfer-error entry, and the reset entry appears one cycle after the first edge with reset low. The bench advances a reference model on the same edge as the design and samples every output one time unit after that edge, so each expected value is compared against the cycle in which it is due.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        EX_NONE  = 4'd0,
        EX_RESET = 4'd1,
        EX_UNDEF = 4'd2,
        EX_SWI   = 4'd3,
        EX_PABT  = 4'd4,
        EX_DABT  = 4'd5,
        EX_ADDR  = 4'd6,
        EX_IRQ   = 4'd7,
        EX_FIQ   = 4'd8
    } exc_e;

    typedef enum logic [2:0] {
        MD_NONE = 3'd0,
        MD_FIQ  = 3'd1,
        MD_IRQ  = 3'd2,
        MD_SVC  = 3'd3,
        MD_ABT  = 3'd4,
        MD_UND  = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        CY_PREF = 2'd0,
        CY_DATA = 2'd1,
        CY_INTL = 2'd2,
        CY_RSVD = 2'd3
    } cyc_e;

    // request slots, index 0 is the highest priority below reset
    localparam int NREQ     = 7;
    localparam int RQ_ADDR  = 0;
    localparam int RQ_DABT  = 1;
    localparam int RQ_FIQ   = 2;
    localparam int RQ_IRQ   = 3;
    localparam int RQ_PABT  = 4;
    localparam int RQ_UNDEF = 5;
    localparam int RQ_SWI   = 6;

    function automatic exc_e slot_to_exc(input int k);
        case (k)
            RQ_ADDR:  return EX_ADDR;
            RQ_DABT:  return EX_DABT;
            RQ_FIQ:   return EX_FIQ;
            RQ_IRQ:   return EX_IRQ;
            RQ_PABT:  return EX_PABT;
            RQ_UNDEF: return EX_UNDEF;
            RQ_SWI:   return EX_SWI;
            default:  return EX_NONE;
        endcase
    endfunction

    // word index of the vector within the first eight words
    function automatic logic [2:0] vec_word(input exc_e e);
        case (e)
            EX_RESET: return 3'd0;
            EX_UNDEF: return 3'd1;
            EX_SWI:   return 3'd2;
            EX_PABT:  return 3'd3;
            EX_DABT:  return 3'd4;
            EX_ADDR:  return 3'd5;
            EX_IRQ:   return 3'd6;
            EX_FIQ:   return 3'd7;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_pin_sync.sv
module exc_pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] sync_n
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                sync_n[b] <= 1'b1;
            end else begin
                sync_n[b] <= pin_n[b];
            end
        end
    end

endmodule

// File: rtl/exc_event_capture.sv
module exc_event_capture
    import exc_pkg::*;
#(
    parameter int DADDR_W = 32,
    parameter int LIM_BIT = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               abort_in,
    input  cyc_e               cyc,
    input  logic [DADDR_W-1:0] daddr,
    input  logic               xfer_valid,
    input  logic               is_branch,
    input  logic               is_block,
    input  logic               blk_first,
    input  logic               flush,
    input  exc_e               commit,
    output logic               pend_addr,
    output logic               pend_dabt,
    output logic               pab_mark
);

    localparam logic [DADDR_W-1:0] LO_MASK = DADDR_W'((64'd1 << LIM_BIT) - 64'd1);

    logic addr_bad;
    logic first_word;
    logic new_addr;
    logic new_dabt;
    logic new_pab;

    always_comb begin
        addr_bad   = |(daddr & ~LO_MASK);
        first_word = !is_block || blk_first;
        new_addr   = xfer_valid && (cyc == CY_DATA) && !is_branch && first_word && addr_bad;
        new_dabt   = abort_in && (cyc == CY_DATA) && !new_addr;
        new_pab    = abort_in && (cyc == CY_PREF);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pend_addr <= 1'b0;
            pend_dabt <= 1'b0;
            pab_mark  <= 1'b0;
        end else begin
            pend_addr <= (pend_addr && (commit != EX_ADDR)) || new_addr;
            pend_dabt <= (pend_dabt && (commit != EX_DABT)) || new_dabt;
            pab_mark  <= (pab_mark && (commit != EX_PABT) && !flush) || new_pab;
        end
    end

    // R7: a flush with no new prefetch abort leaves no mark behind
    a_r7_flush_drops: assert property (@(posedge clk) disable iff (rst)
        (flush && !new_pab) |=> !pab_mark);

    // R6: an internal-cycle abort never creates a pending data abort
    a_r6_internal_ignored: assert property (@(posedge clk) disable iff (rst)
        (!pend_dabt && abort_in && (cyc == CY_INTL || cyc == CY_RSVD)) |=> !pend_dabt);

endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant,
    output exc_e            winner
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < NREQ; k++) begin
            if (req[k] && !found) begin
                grant[k] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        winner = EX_NONE;
        for (int k = 0; k < NREQ; k++) begin
            if (grant[k]) begin
                winner = slot_to_exc(k);
            end
        end
    end

    // R10: at most one request granted, and only a requesting slot
    a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  exc_e             winner,
    input  logic             fiq_ok,
    output exc_e             commit,
    output logic             take_exc,
    output logic [VEC_W-1:0] vec_addr,
    output mode_e            mode_out,
    output logic             set_f,
    output logic             set_i
);

    typedef enum logic [1:0] {
        S_HOLD  = 2'd0,
        S_RUN   = 2'd1,
        S_CHAIN = 2'd2
    } state_e;

    state_e state;
    state_e state_nx;
    exc_e   cur_exc;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state   <= S_HOLD;
            cur_exc <= EX_NONE;
        end else begin
            state   <= state_nx;
            cur_exc <= commit;
        end
    end

    always_comb begin
        state_nx = state;
        commit   = EX_NONE;
        unique case (state)
            S_HOLD: begin
                commit   = EX_RESET;
                state_nx = S_RUN;
            end
            S_RUN: begin
                if (boundary && (winner != EX_NONE)) begin
                    commit = winner;
                    if (((winner == EX_ADDR) || (winner == EX_DABT)) && fiq_ok) begin
                        state_nx = S_CHAIN;
                    end
                end
            end
            S_CHAIN: begin
                commit   = EX_FIQ;
                state_nx = S_RUN;
            end
            default: begin
                state_nx = S_RUN;
            end
        endcase
    end

    always_comb begin
        take_exc = (cur_exc != EX_NONE);
        vec_addr = '0;
        vec_addr[4:2] = vec_word(cur_exc);
        set_i    = take_exc;
        set_f    = (cur_exc == EX_FIQ) || (cur_exc == EX_RESET);
        unique case (cur_exc)
            EX_FIQ:                    mode_out = MD_FIQ;
            EX_IRQ:                    mode_out = MD_IRQ;
            EX_RESET, EX_SWI, EX_ADDR: mode_out = MD_SVC;
            EX_PABT, EX_DABT:          mode_out = MD_ABT;
            EX_UNDEF:                  mode_out = MD_UND;
            default:                   mode_out = MD_NONE;
        endcase
    end

    // R11: the first edge after reset release commits the reset entry
    a_r11_reset_first: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD) |=> (take_exc && (vec_addr == '0) && set_f));

    // R8: the chain state is always followed by the fast-interrupt entry
    a_r8_chain_fiq: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHAIN) |=> (mode_out == MD_FIQ));

    // R12: no boundary in the run state means no entry next cycle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ((state == S_RUN) && !boundary) |=> !take_exc);

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int DADDR_W = 32,
    parameter int LIM_BIT = 26,
    parameter int VEC_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nfiq_pin,
    input  logic               nirq_pin,
    input  logic               boundary,
    input  logic               abort_in,
    input  logic [1:0]         cyc_type,
    input  logic [DADDR_W-1:0] daddr,
    input  logic               xfer_valid,
    input  logic               is_branch,
    input  logic               is_block,
    input  logic               blk_first,
    input  logic               flush,
    input  logic               undef_dec,
    input  logic               swi_dec,
    input  logic               flag_f,
    input  logic               flag_i,
    output logic               take_exc,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [2:0]         mode_out,
    output logic               set_f,
    output logic               set_i
);

    localparam int NPIN = 2;

    logic [NPIN-1:0] pins_sync_n;
    logic            pend_addr;
    logic            pend_dabt;
    logic            pab_mark;
    logic            fiq_ok;
    logic            irq_ok;
    logic [NREQ-1:0] req;
    logic [NREQ-1:0] grant;
    exc_e            winner;
    exc_e            commit;
    mode_e           mode_q;

    exc_pin_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_n  ({nirq_pin, nfiq_pin}),
        .sync_n (pins_sync_n)
    );

    exc_event_capture #(.DADDR_W(DADDR_W), .LIM_BIT(LIM_BIT)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .abort_in   (abort_in),
        .cyc        (cyc_e'(cyc_type)),
        .daddr      (daddr),
        .xfer_valid (xfer_valid),
        .is_branch  (is_branch),
        .is_block   (is_block),
        .blk_first  (blk_first),
        .flush      (flush),
        .commit     (commit),
        .pend_addr  (pend_addr),
        .pend_dabt  (pend_dabt),
        .pab_mark   (pab_mark)
    );

    always_comb begin
        fiq_ok        = !pins_sync_n[0] && !flag_f;
        irq_ok        = !pins_sync_n[1] && !flag_i;
        req           = '0;
        req[RQ_ADDR]  = pend_addr;
        req[RQ_DABT]  = pend_dabt;
        req[RQ_FIQ]   = fiq_ok;
        req[RQ_IRQ]   = irq_ok;
        req[RQ_PABT]  = pab_mark;
        req[RQ_UNDEF] = undef_dec;
        req[RQ_SWI]   = swi_dec;
    end

    exc_prio_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .grant  (grant),
        .winner (winner)
    );

    exc_entry_seq #(.VEC_W(VEC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .winner   (winner),
        .fiq_ok   (fiq_ok),
        .commit   (commit),
        .take_exc (take_exc),
        .vec_addr (vec_addr),
        .mode_out (mode_q),
        .set_f    (set_f),
        .set_i    (set_i)
    );

    assign mode_out = mode_q;

    // R3: a fast-interrupt entry masks both interrupt kinds
    a_r3_fiq_masks: assert property (@(posedge clk) disable iff (rst)
        (take_exc && (mode_out == 3'd1)) |-> (set_f && set_i));

    // R2: a normal-interrupt entry leaves the fast mask alone
    a_r2_irq_keeps_f: assert property (@(posedge clk) disable iff (rst)
        (take_exc && (mode_out == 3'd2)) |-> (!set_f && set_i));

    // R12: an entry lasts one cycle unless a new boundary or chain follows
    a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
        (take_exc && !boundary && (mode_out != 3'd4) && (mode_out != 3'd3)) |=> !take_exc);

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        nfiq_pin, nirq_pin, boundary, abort_in;
    logic [1:0]  cyc_type;
    logic [31:0] daddr;
    logic        xfer_valid, is_branch, is_block, blk_first, flush;
    logic        undef_dec, swi_dec, flag_f, flag_i;
    logic        take_exc;
    logic [31:0] vec_addr;
    logic [2:0]  mode_out;
    logic        set_f, set_i;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic m_fiq_s, m_irq_s, m_paddr, m_pdabt, m_pab, m_chain, m_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst(rst), .nfiq_pin(nfiq_pin), .nirq_pin(nirq_pin),
        .boundary(boundary), .abort_in(abort_in), .cyc_type(cyc_type),
        .daddr(daddr), .xfer_valid(xfer_valid), .is_branch(is_branch),
        .is_block(is_block), .blk_first(blk_first), .flush(flush),
        .undef_dec(undef_dec), .swi_dec(swi_dec), .flag_f(flag_f),
        .flag_i(flag_i), .take_exc(take_exc), .vec_addr(vec_addr),
        .mode_out(mode_out), .set_f(set_f), .set_i(set_i)
    );

    // codes: 0 none 1 reset 2 undef 3 swi 4 pabt 5 dabt 6 addr 7 irq 8 fiq
    function automatic logic [31:0] exp_vec(input int c);
        case (c)
            2: return 32'h04;  3: return 32'h08;  4: return 32'h0C;
            5: return 32'h10;  6: return 32'h14;  7: return 32'h18;
            8: return 32'h1C;  default: return 32'h00;
        endcase
    endfunction

    function automatic logic [2:0] exp_mode(input int c);
        case (c)
            1, 3, 6: return 3'd3;
            2:       return 3'd5;
            4, 5:    return 3'd4;
            7:       return 3'd2;
            8:       return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            1: return "R11"; 2: return "R9"; 3: return "R9"; 4: return "R7";
            5: return "R8";  6: return "R4"; 7: return "R2"; 8: return "R3";
            default: return "R12";
        endcase
    endfunction

    task automatic check_out(input string tag, input int c);
        logic ok;
        checks++;
        ok = (take_exc == (c != 0));
        if (c != 0) begin
            ok = ok && (vec_addr == exp_vec(c)) && (mode_out == exp_mode(c)) &&
                 (set_f == ((c == 1) || (c == 8))) && (set_i == 1'b1);
        end
        if (!ok) begin
            errors++;
            $display("FAIL %s: take=%0b vec=%h mode=%0d f=%0b i=%0b expected take=%0b vec=%h mode=%0d f=%0b i=%0b",
                     tag, take_exc, vec_addr, mode_out, set_f, set_i,
                     (c != 0), exp_vec(c), exp_mode(c), ((c == 1) || (c == 8)), (c != 0));
        end
    endtask

    task automatic clear_pulses();
        boundary = 0; abort_in = 0; cyc_type = 2'd2; daddr = 32'h0;
        xfer_valid = 0; is_branch = 0; is_block = 0; blk_first = 0;
        flush = 0; undef_dec = 0; swi_dec = 0;
    endtask

    // one clock: model next state from current inputs, advance, compare
    task automatic step(input string tag);
        logic n_addr, n_dabt, n_pab, fok, iok, ch_n;
        int code;
        n_addr = xfer_valid && (cyc_type == 2'd1) && !is_branch &&
                 (!is_block || blk_first) && (daddr[31:26] != 6'd0);
        n_dabt = abort_in && (cyc_type == 2'd1) && !n_addr;
        n_pab  = abort_in && (cyc_type == 2'd0);
        fok = !m_fiq_s && !flag_f;
        iok = !m_irq_s && !flag_i;
        code = 0; ch_n = 0;
        if (m_first) code = 1;
        else if (m_chain) code = 8;
        else if (boundary) begin
            if (m_paddr) code = 6;
            else if (m_pdabt) code = 5;
            else if (fok) code = 8;
            else if (iok) code = 7;
            else if (m_pab) code = 4;
            else if (undef_dec) code = 2;
            else if (swi_dec) code = 3;
            ch_n = ((code == 5) || (code == 6)) && fok;
        end
        @(posedge clk);
        #1;
        m_paddr = (m_paddr && code != 6) || n_addr;
        m_pdabt = (m_pdabt && code != 5) || n_dabt;
        m_pab   = (m_pab && code != 4 && !flush) || n_pab;
        m_fiq_s = nfiq_pin;
        m_irq_s = nirq_pin;
        m_chain = ch_n;
        m_first = 0;
        check_out((tag == "") ? tag_of(code) : tag, code);
        clear_pulses();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: take=%0b expected run to finish", take_exc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; nfiq_pin = 1; nirq_pin = 1; flag_f = 0; flag_i = 0;
        clear_pulses();
        boundary = 1; swi_dec = 1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check_out("R11", 0);          // R11: quiet while reset high
        end
        clear_pulses();
        rst = 0;
        m_fiq_s = 1; m_irq_s = 1; m_paddr = 0; m_pdabt = 0; m_pab = 0;
        m_chain = 0; m_first = 1;
        step("R11");                      // reset vector after release
        step("R12");

        // R1: pin low at the boundary edge itself is not yet seen
        nfiq_pin = 0; boundary = 1; step("R1");
        boundary = 1; step("R1");
        nfiq_pin = 1; step("R1"); step("R1");

        // R2: masked fast interrupt lets normal interrupt win
        nfiq_pin = 0; nirq_pin = 0; flag_f = 1; step("R2");
        boundary = 1; step("R2");
        flag_f = 0; boundary = 1; step("R3");   // R3: fast beats normal
        nfiq_pin = 1; nirq_pin = 1; step("R12"); step("R12");

        // R4 + R6: illegal data address with abort gives one address exception
        xfer_valid = 1; cyc_type = 2'd1; daddr = 32'h0400_0000; abort_in = 1; step("R6");
        boundary = 1; step("R4");
        boundary = 1; step("R6");
        // R4: branch never traps
        xfer_valid = 1; cyc_type = 2'd1; daddr = 32'hFC00_0000; is_branch = 1; step("R4");
        boundary = 1; step("R4");
        // R5: later block words do not trap, first word does
        xfer_valid = 1; cyc_type = 2'd1; daddr = 32'h0800_0010; is_block = 1; blk_first = 0; step("R5");
        boundary = 1; step("R5");
        xfer_valid = 1; cyc_type = 2'd1; daddr = 32'h0800_0010; is_block = 1; blk_first = 1; step("R5");
        boundary = 1; step("R5");
        // R6: internal-cycle abort ignored
        abort_in = 1; cyc_type = 2'd2; step("R6");
        boundary = 1; step("R6");
        // R7: prefetch abort flushed, then one taken
        abort_in = 1; cyc_type = 2'd0; step("R7");
        flush = 1; step("R7");
        boundary = 1; step("R7");
        abort_in = 1; cyc_type = 2'd0; step("R7");
        boundary = 1; step("R7");
        // R8: data abort with enabled fast interrupt chains
        nfiq_pin = 0; flag_f = 1; abort_in = 1; cyc_type = 2'd1; daddr = 32'h100; step("R8");
        flag_f = 0; boundary = 1; step("R8");
        step("R8");
        nfiq_pin = 1; step("R8"); step("R8");
        // R10: normal interrupt beats prefetch abort, which waits
        abort_in = 1; cyc_type = 2'd0; nirq_pin = 0; step("R10");
        boundary = 1; undef_dec = 1; step("R10");
        nirq_pin = 1; step("R10");
        boundary = 1; swi_dec = 1; step("R10");
        // R9: undefined and software interrupt vectors
        boundary = 1; undef_dec = 1; step("R9");
        boundary = 1; swi_dec = 1; step("R9");

        for (int n = 0; n < 4000; n++) begin
            logic [2:0] d;
            boundary = 1'($urandom_range(0, 1));
            abort_in = ($urandom_range(0, 5) == 0);
            cyc_type = 2'($urandom_range(0, 3));
            xfer_valid = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0)
                daddr = {6'($urandom_range(1, 63)), 26'($urandom)};
            else
                daddr = {6'd0, 26'($urandom)};
            is_branch = ($urandom_range(0, 7) == 0);
            is_block  = ($urandom_range(0, 3) == 0);
            blk_first = 1'($urandom_range(0, 1));
            flush     = ($urandom_range(0, 7) == 0);
            d = 3'($urandom_range(0, 9));
            undef_dec = (d == 3'd0);
            swi_dec   = (d == 3'd1);
            if ($urandom_range(0, 9) == 0) nfiq_pin = ~nfiq_pin;
            if ($urandom_range(0, 9) == 0) nirq_pin = ~nirq_pin;
            if ($urandom_range(0, 9) == 0) flag_f = ~flag_f;
            if ($urandom_range(0, 9) == 0) flag_i = ~flag_i;
            step("");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule